// File: doc/BRIEF.md
# Early-Exit Sequential Shift-Add Multiplier

This block multiplies two unsigned W-bit operands one bit at a time and returns a 2W-bit product. Each step looks at the lowest bit of the remaining multiplier. When that bit is set, the step adds the current multiplicand into a product accumulator. The multiplicand then moves one place left and the multiplier one place right.

The operation ends as soon as no set bit is left in the shifted multiplier. The step count is therefore the bit length of the multiplier operand, not a fixed W. A small multiplier such as 3 finishes in two steps, and a zero multiplier finishes with no steps at all.

The block is used in a plain request/response manner. The requester raises `start_i` for one cycle with both operands while `busy_o` is low. It then waits for the one-cycle `done_o` pulse and reads `product_o`, which holds its value until the next accepted start.

Top module: `early_exit_mul`

## Requirements
- R1: After reset `busy_o`, `done_o` and `product_o` are all 0.
- R2: A start accepted while idle clears the accumulator, so `product_o` reads 0 in the cycle after the start when the multiplier is nonzero.
- R3: When `done_o` is high, `product_o` equals the full unsigned 2W-bit product `mcand_i * mplier_i`, for every operand value including both operands at all ones.
- R4: For a nonzero multiplier whose highest set bit is at index h, `done_o` rises exactly h+2 cycles after the cycle in which start was sampled, and `busy_o` is high during the h+1 cycles in between.
- R5: A zero multiplier raises `done_o` in the cycle right after start with `product_o` equal to 0, and `busy_o` never rises.
- R6: Termination needs every bit of the shifted multiplier to be zero, including bits above the lowest byte. A multiplier of 0x0100 therefore takes 9 steps, and a multiplier with only its top bit set takes W steps.
- R7: `done_o` is high for exactly one cycle per operation and is never high together with `busy_o`.
- R8: `start_i` is ignored while `busy_o` is high. The running operation completes with its original operands and original latency.
- R9: While idle and without a new start, `product_o` keeps its value after `done_o`.
- R10: The addition carries from the low W bits of the accumulator into the high W bits. For example, 0xFFFF * 0xFFFF with W=16 yields 0xFFFE0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, sampled when idle |
| mcand_i | input | W | Multiplicand operand |
| mplier_i | input | W | Multiplier operand |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| product_o | output | 2W | Product, held until next start |

## Verification
A wrong accumulator or multiplicand shift shows up as a wrong `product_o` at the `done_o` pulse of the same operation. A faulty zero test or multiplier shift moves `done_o` by one or more cycles, or makes it rise early when a set bit sits only in an upper byte. Because latency is data-dependent, the bench predicts the exact done cycle from each multiplier's bit length. Any extra or missing step is therefore caught in the same operation. Operand pairs that carry across the accumulator halves, and starts issued while the unit is busy, expose faults in the carry path and in the gating of the start input.

// File: rtl/early_exit_mul_pkg.sv
package early_exit_mul_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } mul_state_e;

  localparam int unsigned LANE_W = 8;
endpackage

// File: rtl/mul_zero_detect.sv
module mul_zero_detect #(
  parameter int unsigned W      = 16,
  parameter int unsigned LANE_W = 8
) (
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  localparam int unsigned NL    = (W + LANE_W - 1) / LANE_W;
  localparam int unsigned PAD_W = NL * LANE_W;

  logic [PAD_W-1:0] padded;
  logic [NL-1:0]    lane_nz;

  always_comb begin
    padded        = '0;
    padded[W-1:0] = val_i;
  end

  // every lane must be clear, not just the low one
  for (genvar l = 0; l < NL; l++) begin : g_lane
    assign lane_nz[l] = |padded[l*LANE_W +: LANE_W];
  end

  assign zero_o = ~|lane_nz;
endmodule

// File: rtl/mul_ctrl.sv
module mul_ctrl
  import early_exit_mul_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic op_zero_i,
  input  logic last_i,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);
  mul_state_e state_q, state_d;
  logic       done_q, done_d;

  assign busy_o = (state_q == ST_RUN);
  assign load_o = start_i && !busy_o;
  assign step_o = busy_o;
  assign done_o = done_q;

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          if (op_zero_i) done_d  = 1'b1;
          else           state_d = ST_RUN;
        end
      end
      ST_RUN: begin
        if (last_i) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  a_r7_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r7_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  a_r8_no_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !last_i |=> busy_o);
endmodule

// File: rtl/mul_datapath.sv
module mul_datapath #(
  parameter int unsigned W      = 16,
  parameter int unsigned LANE_W = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic           step_i,
  input  logic [W-1:0]   mcand_i,
  input  logic [W-1:0]   mplier_i,
  output logic           op_zero_o,
  output logic           last_o,
  output logic [2*W-1:0] acc_o
);
  localparam int unsigned PW = 2 * W;

  logic [PW-1:0] mcand_q;
  logic [W-1:0]  mplier_q;
  logic [PW-1:0] acc_q;
  logic [W-1:0]  mplier_shr;
  logic [W:0]    sum_lo;
  logic [W-1:0]  sum_hi;
  logic [PW-1:0] acc_sum;

  assign mplier_shr = {1'b0, mplier_q[W-1:1]};

  mul_zero_detect #(.W(W), .LANE_W(LANE_W)) u_zd_op (
    .val_i (mplier_i),
    .zero_o(op_zero_o)
  );

  mul_zero_detect #(.W(W), .LANE_W(LANE_W)) u_zd_next (
    .val_i (mplier_shr),
    .zero_o(last_o)
  );

  // split add: low half carry ripples into high half
  assign sum_lo  = {1'b0, acc_q[W-1:0]} + {1'b0, mcand_q[W-1:0]};
  assign sum_hi  = acc_q[PW-1:W] + mcand_q[PW-1:W] + {{(W-1){1'b0}}, sum_lo[W]};
  assign acc_sum = {sum_hi, sum_lo[W-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcand_q  <= '0;
      mplier_q <= '0;
      acc_q    <= '0;
    end else if (load_i) begin
      mcand_q  <= {{W{1'b0}}, mcand_i};
      mplier_q <= mplier_i;
      acc_q    <= '0;
    end else if (step_i) begin
      if (mplier_q[0]) acc_q <= acc_sum;
      mcand_q  <= {mcand_q[PW-2:0], 1'b0};
      mplier_q <= mplier_shr;
    end
  end

  assign acc_o = acc_q;

  a_r6_step_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> mplier_q != '0);
  a_r10_acc_monotonic: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> acc_q >= $past(acc_q));
  a_r2_load_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> acc_q == '0);
endmodule

// File: rtl/early_exit_mul.sv
module early_exit_mul
  import early_exit_mul_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [W-1:0]   mcand_i,
  input  logic [W-1:0]   mplier_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [2*W-1:0] product_o
);
  logic load, step, op_zero, last;

  mul_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .op_zero_i(op_zero),
    .last_i   (last),
    .load_o   (load),
    .step_o   (step),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  mul_datapath #(.W(W), .LANE_W(LANE_W)) u_dp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .step_i   (step),
    .mcand_i  (mcand_i),
    .mplier_i (mplier_i),
    .op_zero_o(op_zero),
    .last_o   (last),
    .acc_o    (product_o)
  );

  a_r5_zero_fast: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && mplier_i == '0 |=> done_o && product_o == '0);
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !start_i |=> $stable(product_o));
  a_r4_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && mplier_i != '0 |=> busy_o);
endmodule

// File: tb/early_exit_mul_tb_top.sv
module early_exit_mul_tb_top;
  localparam int unsigned W  = 16;
  localparam int unsigned NV = 10;
  localparam logic [W-1:0] VA [NV] = '{16'd7, 16'd5, 16'h1234, 16'hFFFF, 16'h00FF,
                                       16'h8000, 16'h0001, 16'hABCD, 16'h0000, 16'h4321};
  localparam logic [W-1:0] VB [NV] = '{16'd5, 16'd3, 16'h0100, 16'hFFFF, 16'h0101,
                                       16'h8000, 16'h0001, 16'h0000, 16'h7777, 16'h0003};

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic busy, done;
  logic [2*W-1:0] prod;
  int tests = 0, fails = 0;

  always #2 clk = ~clk;

  early_exit_mul #(.W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mcand_i(a), .mplier_i(b),
    .busy_o(busy), .done_o(done), .product_o(prod)
  );

  function automatic int bitlen(logic [W-1:0] v);
    int n = 0;
    for (int i = 0; i < int'(W); i++) if (v[i]) n = i + 1;
    return n;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // run one op; optionally poke start with other operands while busy (R8)
  task automatic run_op(logic [W-1:0] x, logic [W-1:0] y, bit poke);
    logic [2*W-1:0] exp_p = {{W{1'b0}}, x} * {{W{1'b0}}, y};
    int cyc = 0;
    logic [2*W-1:0] held;
    @(negedge clk);
    a = x; b = y; start = 1'b1;
    @(negedge clk);
    start = 1'b0; cyc = 1;
    if (y != 0) begin
      chk("R2 cleared", 64'(prod), 64'd0);
      chk("R4 busy", 64'(busy), 64'd1);
      if (poke) begin a = ~x; b = 16'h0001; start = 1'b1; end
    end
    while (!done && cyc < 4 * int'(W)) begin
      if (busy === 1'b0 && y != 0) chk("R4 busy gap", 64'(busy), 64'd1);
      @(negedge clk); cyc++;
      start = 1'b0;
    end
    chk(poke ? "R8 latency" : (y == 0 ? "R5 latency" : "R4 R6 latency"),
        64'(cyc), 64'(bitlen(y) + 1));
    chk(y == 0 ? "R5 product" : (poke ? "R8 product" : "R3 R10 product"),
        64'(prod), 64'(exp_p));
    chk("R7 busy low at done", 64'(busy), 64'd0);
    held = prod;
    @(negedge clk);
    chk("R7 pulse", 64'(done), 64'd0);
    @(negedge clk);
    chk("R9 hold", 64'(prod), 64'(held));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", 64'(busy), 64'd0);
    chk("R1 done", 64'(done), 64'd0);
    chk("R1 product", 64'(prod), 64'd0);
    rst_n = 1'b1;
    for (int i = 0; i < int'(NV); i++) run_op(VA[i], VB[i], 1'b0);
    // directed corners
    run_op(16'hFFFF, 16'h8000, 1'b0);  // R6 top bit only, W steps
    run_op(16'h00FF, 16'h0000, 1'b0);  // R5 zero multiplier
    run_op(16'h0123, 16'h0F0F, 1'b1);  // R8 start while busy
    run_op(16'hFFFF, 16'hFFFF, 1'b1);  // R10 carry, R8
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule